// File: doc/BRIEF.md
# Single-Issue Core Memory Sequencer

This block is the control state machine of a non-pipelined processor core. It carries one instruction at a time through its life cycle: it asks for the fetch address to be translated, sends the fetch to the instruction port, waits for the instruction to come back, lets the execution stage decide whether the instruction touches memory, and in that case asks for a data translation and sends one access to the data port. Decode, arithmetic and the caches themselves are outside the block; it only owns the sequence, the redirection after a translation fault, the suspend/activate control and the drain handshake.

Each memory port carries a request with valid/ready. A request that is offered but not accepted is not repeated by itself: the sequencer parks in a retry state with the request valid low and offers it again only in a cycle where the port raises its retry input, and the request counts as sent on any cycle where valid and ready are both high. Responses come back on a valid/ready pair. A response is captured in a one-entry holding register and acted upon in the following cycle. While that register is full the response ready is low, so a second response offered in that cycle is refused and must be offered again later.

A drain request stops the core at the next instruction boundary and raises a drained indication there; while the drain request stays high no fetch is started. A status output gives the number of clock cycles elapsed at the most recent state change.

Top module: `core_mem_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, the state output is 0 (idle), the drained flag and all request strobes are low, the cycle count is 0, and both response ready outputs are high.
- R2: An activate pulse sampled in idle with delay value D makes the state running and raises the fetch strobe exactly D+1 clock edges after the edge that sampled it; activate is ignored when not idle or while a delay is already counting.
- R3: When fetch translation completes without fault, the instruction request valid is raised in the same cycle; if ready is low the state becomes 2 (instruction retry) with valid low, valid is raised again only in cycles where the retry input is high, and acceptance moves the state to 3 (instruction wait).
- R4: A response accepted at a clock edge is acted upon in the cycle after that edge, during which the response ready of that port is low so that a second response is refused; ready is high again one cycle later.
- R5: When the instruction is handled and the execution input says it does not reference memory, the program-counter advance pulses in that cycle and the state returns to 1 (running), where the fetch strobe for the next instruction is raised in the following cycle unless suspended or draining.
- R6: When the instruction references memory, the data translation request pulses in the handling cycle and the state becomes 4 (data translation wait).
- R7: A data translation without fault raises the data request valid in the same cycle; refusal leads to state 5 (data retry) with the same retry rule as R3, acceptance to state 6 (data wait), and the data response completes the instruction with one advance pulse and a return to running.
- R8: A translation fault on fetch or data pulses the redirect output, raises no port request in that cycle, enters state 7 (faulting) for one cycle with no advance pulse, and then returns to running and starts a new fetch.
- R9: A suspend pulse while busy lets the current instruction finish and then moves the state to idle without raising another fetch strobe.
- R10: The drained flag rises one cycle after a drain request is sampled in idle or at a running instruction boundary; during an instruction it stays low until the instruction has completed; no fetch strobe is raised while the drain request is high.
- R11: On every state change the cycle count output takes the number of clock edges since reset release, and it holds its value while the state does not change.
- R12: At most one of fetch strobe, instruction request valid, data translation request and data request valid is high in any cycle, so only one instruction and at most one data access are in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| activate_i | input | 1 | Start the core from idle |
| act_delay_i | input | DLY_W | Cycles to wait after activate before fetching |
| suspend_i | input | 1 | Stop after the current instruction |
| drain_req_i | input | 1 | Request a halt at the next instruction boundary |
| fxlate_done_i | input | 1 | Fetch address translation finished |
| fxlate_fault_i | input | 1 | Fetch translation faulted (with done) |
| fetch_strobe_o | output | 1 | Start translation of the next fetch address |
| ic_req_valid_o | output | 1 | Instruction port request valid |
| ic_req_ready_i | input | 1 | Instruction port accepts the request |
| ic_retry_i | input | 1 | Instruction port invites a new attempt |
| ic_rsp_valid_i | input | 1 | Instruction response valid |
| ic_rsp_ready_o | output | 1 | Instruction response can be taken |
| exec_is_mem_i | input | 1 | Executed instruction references memory |
| dxlate_req_o | output | 1 | Start translation of the data address |
| dxlate_done_i | input | 1 | Data translation finished |
| dxlate_fault_i | input | 1 | Data translation faulted (with done) |
| dc_req_valid_o | output | 1 | Data port request valid |
| dc_req_ready_i | input | 1 | Data port accepts the request |
| dc_retry_i | input | 1 | Data port invites a new attempt |
| dc_rsp_valid_i | input | 1 | Data response valid |
| dc_rsp_ready_o | output | 1 | Data response can be taken |
| pc_advance_o | output | 1 | Instruction completed, step the program counter |
| pc_redirect_o | output | 1 | Fault, send the program counter to the handler |
| drained_o | output | 1 | Core is halted for drain |
| state_o | output | 3 | Current sequencer state code |
| cycles_o | output | CYC_W | Elapsed cycles at the last state change |

## Verification
The assertions rely on the surroundings behaving like a single-requester memory system: a translation done arrives only while a translation is pending, a response is offered only after its request was accepted, and retry is raised only to a port whose request was refused. The bench drives each instruction as one scripted transaction in which every done, retry and response pulse is issued only in the state that expects it, and the only stimulus that breaks the one-response rule is the deliberate second data response, which the design is required to refuse.

// File: rtl/cms_pkg.sv
package cms_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_RUN      = 3'd1,
    ST_IC_RETRY = 3'd2,
    ST_IC_WAIT  = 3'd3,
    ST_DTB_WAIT = 3'd4,
    ST_DC_RETRY = 3'd5,
    ST_DC_WAIT  = 3'd6,
    ST_FAULT    = 3'd7
  } seq_state_e;

  localparam int unsigned N_PORTS = 2;
  localparam int unsigned PORT_I  = 0;
  localparam int unsigned PORT_D  = 1;

endpackage

// File: rtl/cms_rsp_align.sv
// One-entry holding register: a response is taken on the edge and handed to
// the sequencer on the following cycle; a further response is refused while full.
module cms_rsp_align (
  input  logic clk,
  input  logic rst_n,
  input  logic rsp_valid_i,
  output logic rsp_ready_o,
  input  logic take_i,
  output logic pend_o
);
  logic full_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
    end else begin
      full_q <= (full_q && !take_i) || (rsp_valid_i && !full_q);
    end
  end

  assign rsp_ready_o = !full_q;
  assign pend_o      = full_q;
endmodule

// File: rtl/cms_wake_timer.sv
// Counts the activation delay; fires once when it runs out.
module cms_wake_timer #(
  parameter int unsigned DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [DLY_W-1:0] delay_i,
  output logic             busy_o,
  output logic             fire_o
);
  logic             armed_q;
  logic [DLY_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (start_i) begin
      armed_q <= 1'b1;
      cnt_q   <= delay_i;
    end else if (armed_q) begin
      if (cnt_q == '0) armed_q <= 1'b0;
      else             cnt_q   <= cnt_q - 1'b1;
    end
  end

  assign busy_o = armed_q;
  assign fire_o = armed_q && (cnt_q == '0);
endmodule

// File: rtl/cms_cycle_acc.sv
// Free-running edge count, latched into the status output on each state change.
module cms_cycle_acc #(
  parameter int unsigned CYC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chg_i,
  output logic [CYC_W-1:0] cycles_o
);
  logic [CYC_W-1:0] tick_q;
  logic [CYC_W-1:0] acc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tick_q <= '0;
      acc_q  <= '0;
    end else begin
      tick_q <= tick_q + 1'b1;
      if (chg_i) acc_q <= tick_q + 1'b1;
    end
  end

  assign cycles_o = acc_q;
endmodule

// File: rtl/core_mem_seq.sv
module core_mem_seq
  import cms_pkg::*;
#(
  parameter int unsigned DLY_W = 8,
  parameter int unsigned CYC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             activate_i,
  input  logic [DLY_W-1:0] act_delay_i,
  input  logic             suspend_i,
  input  logic             drain_req_i,
  input  logic             fxlate_done_i,
  input  logic             fxlate_fault_i,
  output logic             fetch_strobe_o,
  output logic             ic_req_valid_o,
  input  logic             ic_req_ready_i,
  input  logic             ic_retry_i,
  input  logic             ic_rsp_valid_i,
  output logic             ic_rsp_ready_o,
  input  logic             exec_is_mem_i,
  output logic             dxlate_req_o,
  input  logic             dxlate_done_i,
  input  logic             dxlate_fault_i,
  output logic             dc_req_valid_o,
  input  logic             dc_req_ready_i,
  input  logic             dc_retry_i,
  input  logic             dc_rsp_valid_i,
  output logic             dc_rsp_ready_o,
  output logic             pc_advance_o,
  output logic             pc_redirect_o,
  output logic             drained_o,
  output logic [2:0]       state_o,
  output logic [CYC_W-1:0] cycles_o
);

  seq_state_e st_q, st_d;
  logic       fpend_q, fpend_d;   // fetch translation outstanding
  logic       spend_q, spend_d;   // suspend requested while busy
  logic       drained_q;

  logic [N_PORTS-1:0] rsp_v, rsp_rdy, take_v, pend_v;
  logic               issue_i, issue_d;
  logic               wake_start, wake_busy, wake_fire;
  logic               boundary;

  assign rsp_v[PORT_I] = ic_rsp_valid_i;
  assign rsp_v[PORT_D] = dc_rsp_valid_i;

  for (genvar p = 0; p < N_PORTS; p++) begin : g_align
    cms_rsp_align u_align (
      .clk        (clk),
      .rst_n      (rst_n),
      .rsp_valid_i(rsp_v[p]),
      .rsp_ready_o(rsp_rdy[p]),
      .take_i     (take_v[p]),
      .pend_o     (pend_v[p])
    );
  end

  assign ic_rsp_ready_o = rsp_rdy[PORT_I];
  assign dc_rsp_ready_o = rsp_rdy[PORT_D];

  assign wake_start = activate_i && (st_q == ST_IDLE) && !wake_busy;

  cms_wake_timer #(.DLY_W(DLY_W)) u_wake (
    .clk    (clk),
    .rst_n  (rst_n),
    .start_i(wake_start),
    .delay_i(act_delay_i),
    .busy_o (wake_busy),
    .fire_o (wake_fire)
  );

  assign boundary = (st_q == ST_RUN) && !fpend_q;

  always_comb begin
    st_d           = st_q;
    fpend_d        = fpend_q;
    spend_d        = spend_q;
    fetch_strobe_o = 1'b0;
    issue_i        = 1'b0;
    issue_d        = 1'b0;
    take_v         = '0;
    dxlate_req_o   = 1'b0;
    pc_advance_o   = 1'b0;
    pc_redirect_o  = 1'b0;
    if (suspend_i && (st_q != ST_IDLE)) spend_d = 1'b1;
    unique case (st_q)
      ST_IDLE: begin
        if (wake_fire) st_d = ST_RUN;
      end
      ST_RUN: begin
        if (!fpend_q) begin
          if (spend_q || suspend_i) begin
            st_d    = ST_IDLE;
            spend_d = 1'b0;
          end else if (!drain_req_i) begin
            fetch_strobe_o = 1'b1;
            fpend_d        = 1'b1;
          end
        end else if (fxlate_done_i) begin
          fpend_d = 1'b0;
          if (fxlate_fault_i) begin
            pc_redirect_o = 1'b1;
            st_d          = ST_FAULT;
          end else begin
            issue_i = 1'b1;
            st_d    = ic_req_ready_i ? ST_IC_WAIT : ST_IC_RETRY;
          end
        end
      end
      ST_IC_RETRY: begin
        if (ic_retry_i && ic_req_ready_i) st_d = ST_IC_WAIT;
      end
      ST_IC_WAIT: begin
        if (pend_v[PORT_I]) begin
          take_v[PORT_I] = 1'b1;
          if (exec_is_mem_i) begin
            dxlate_req_o = 1'b1;
            st_d         = ST_DTB_WAIT;
          end else begin
            pc_advance_o = 1'b1;
            st_d         = ST_RUN;
          end
        end
      end
      ST_DTB_WAIT: begin
        if (dxlate_done_i) begin
          if (dxlate_fault_i) begin
            pc_redirect_o = 1'b1;
            st_d          = ST_FAULT;
          end else begin
            issue_d = 1'b1;
            st_d    = dc_req_ready_i ? ST_DC_WAIT : ST_DC_RETRY;
          end
        end
      end
      ST_DC_RETRY: begin
        if (dc_retry_i && dc_req_ready_i) st_d = ST_DC_WAIT;
      end
      ST_DC_WAIT: begin
        if (pend_v[PORT_D]) begin
          take_v[PORT_D] = 1'b1;
          pc_advance_o   = 1'b1;
          st_d           = ST_RUN;
        end
      end
      ST_FAULT: begin
        st_d = ST_RUN;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign ic_req_valid_o = issue_i || ((st_q == ST_IC_RETRY) && ic_retry_i);
  assign dc_req_valid_o = issue_d || ((st_q == ST_DC_RETRY) && dc_retry_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      fpend_q   <= 1'b0;
      spend_q   <= 1'b0;
      drained_q <= 1'b0;
    end else begin
      st_q      <= st_d;
      fpend_q   <= fpend_d;
      spend_q   <= spend_d;
      drained_q <= drain_req_i && ((st_q == ST_IDLE) || boundary);
    end
  end

  assign drained_o = drained_q;
  assign state_o   = st_q;

  cms_cycle_acc #(.CYC_W(CYC_W)) u_cyc (
    .clk     (clk),
    .rst_n   (rst_n),
    .chg_i   (st_d != st_q),
    .cycles_o(cycles_o)
  );

endmodule

// File: rtl/cms_seq_chk.sv
module cms_seq_chk #(
  parameter int unsigned CYC_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       state_o,
  input logic             fetch_strobe_o,
  input logic             ic_req_valid_o,
  input logic             dxlate_req_o,
  input logic             dc_req_valid_o,
  input logic             dc_rsp_valid_i,
  input logic             dc_rsp_ready_o,
  input logic             pc_advance_o,
  input logic             pc_redirect_o,
  input logic             drain_req_i,
  input logic             drained_o,
  input logic [CYC_W-1:0] cycles_o
);

  // R3
  ic_req_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ic_req_valid_o |-> (state_o == 3'd1 || state_o == 3'd2));

  // R4
  dc_rsp_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dc_rsp_valid_i && dc_rsp_ready_o) |=> !dc_rsp_ready_o);

  // R5
  advance_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_advance_o |=> (state_o == 3'd1));

  // R8
  redirect_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_redirect_o |=> (state_o == 3'd7));

  // R8
  redirect_noreq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_redirect_o |-> (!ic_req_valid_o && !dc_req_valid_o));

  // R8
  fault_noadv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd7) |-> !pc_advance_o);

  // R9
  idle_nofetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd0) |-> !fetch_strobe_o);

  // R10
  drain_nofetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drain_req_i |-> !fetch_strobe_o);

  // R10
  drained_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drained_o |-> $past(drain_req_i));

  // R11
  cycles_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(state_o) |-> $stable(cycles_o));

  // R12
  single_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fetch_strobe_o, ic_req_valid_o, dxlate_req_o, dc_req_valid_o}));

endmodule

bind core_mem_seq cms_seq_chk #(.CYC_W(CYC_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .state_o       (state_o),
  .fetch_strobe_o(fetch_strobe_o),
  .ic_req_valid_o(ic_req_valid_o),
  .dxlate_req_o  (dxlate_req_o),
  .dc_req_valid_o(dc_req_valid_o),
  .dc_rsp_valid_i(dc_rsp_valid_i),
  .dc_rsp_ready_o(dc_rsp_ready_o),
  .pc_advance_o  (pc_advance_o),
  .pc_redirect_o (pc_redirect_o),
  .drain_req_i   (drain_req_i),
  .drained_o     (drained_o),
  .cycles_o      (cycles_o)
);

// File: tb/tb_core_mem_seq.sv
module tb_core_mem_seq;
  localparam int unsigned DLY_W = 8;
  localparam int unsigned CYC_W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic activate_i = 1'b0;
  logic [DLY_W-1:0] act_delay_i = '0;
  logic suspend_i = 1'b0, drain_req_i = 1'b0;
  logic fxlate_done_i = 1'b0, fxlate_fault_i = 1'b0;
  logic fetch_strobe_o, ic_req_valid_o, ic_rsp_ready_o;
  logic ic_req_ready_i = 1'b0, ic_retry_i = 1'b0, ic_rsp_valid_i = 1'b0;
  logic exec_is_mem_i = 1'b0;
  logic dxlate_req_o;
  logic dxlate_done_i = 1'b0, dxlate_fault_i = 1'b0;
  logic dc_req_valid_o, dc_rsp_ready_o;
  logic dc_req_ready_i = 1'b0, dc_retry_i = 1'b0, dc_rsp_valid_i = 1'b0;
  logic pc_advance_o, pc_redirect_o, drained_o;
  logic [2:0] state_o;
  logic [CYC_W-1:0] cycles_o;

  int total = 0;
  int bad = 0;
  int edge_cnt = 0;
  bit finished = 0;
  int exp_q[$];

  always #10 clk = ~clk;

  core_mem_seq #(.DLY_W(DLY_W), .CYC_W(CYC_W)) dut (
    .clk(clk), .rst_n(rst_n), .activate_i(activate_i), .act_delay_i(act_delay_i),
    .suspend_i(suspend_i), .drain_req_i(drain_req_i),
    .fxlate_done_i(fxlate_done_i), .fxlate_fault_i(fxlate_fault_i),
    .fetch_strobe_o(fetch_strobe_o),
    .ic_req_valid_o(ic_req_valid_o), .ic_req_ready_i(ic_req_ready_i),
    .ic_retry_i(ic_retry_i), .ic_rsp_valid_i(ic_rsp_valid_i),
    .ic_rsp_ready_o(ic_rsp_ready_o), .exec_is_mem_i(exec_is_mem_i),
    .dxlate_req_o(dxlate_req_o), .dxlate_done_i(dxlate_done_i),
    .dxlate_fault_i(dxlate_fault_i),
    .dc_req_valid_o(dc_req_valid_o), .dc_req_ready_i(dc_req_ready_i),
    .dc_retry_i(dc_retry_i), .dc_rsp_valid_i(dc_rsp_valid_i),
    .dc_rsp_ready_o(dc_rsp_ready_o),
    .pc_advance_o(pc_advance_o), .pc_redirect_o(pc_redirect_o),
    .drained_o(drained_o), .state_o(state_o), .cycles_o(cycles_o)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  always @(posedge clk) if (rst_n) edge_cnt++;

  // Monitor: pops expected completion events and checks the cycle count
  logic [2:0] prev_st = 3'd0;
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      if (state_o != prev_st) chk(cycles_o == edge_cnt, "R11 count", cycles_o, edge_cnt);
      prev_st = state_o;
      if (pc_advance_o || pc_redirect_o) begin
        int code;
        code = (pc_advance_o ? 1 : 0) + (pc_redirect_o ? 2 : 0);
        if (exp_q.size() == 0) chk(1'b0, "R5/R8 unexpected event", code, 0);
        else begin
          int e;
          e = exp_q.pop_front();
          chk(code == e, "R5/R8 event kind", code, e);
        end
      end
    end
  end

  // Step to the next cycle; single-cycle stimulus returns to zero
  task automatic nxt();
    @(negedge clk);
    activate_i = 0; suspend_i = 0;
    fxlate_done_i = 0; fxlate_fault_i = 0;
    ic_req_ready_i = 0; ic_retry_i = 0; ic_rsp_valid_i = 0;
    exec_is_mem_i = 0;
    dxlate_done_i = 0; dxlate_fault_i = 0;
    dc_req_ready_i = 0; dc_retry_i = 0; dc_rsp_valid_i = 0;
  endtask

  task automatic fault_tail();
    nxt(); #1; chk(state_o == 3'd7, "R8 faulting", state_o, 7);
    nxt(); #1; chk(state_o == 3'd1, "R8 back to running", state_o, 1);
  endtask

  // Driver: one instruction, entered in the cycle where the fetch strobe is high
  task automatic run_instr(bit ffault, int ic_ref, bit ismem, bit dfault,
                           int dc_ref, int dc_lat, bit drain_mid, bit susp_mid);
    nxt();
    if (drain_mid) drain_req_i = 1;
    if (susp_mid) suspend_i = 1;
    fxlate_done_i = 1; fxlate_fault_i = ffault; ic_req_ready_i = (ic_ref == 0);
    if (ffault) exp_q.push_back(2);
    #1;
    if (ffault) begin
      chk(!ic_req_valid_o, "R8 no fetch request", ic_req_valid_o, 0);
      fault_tail();
      return;
    end
    chk(ic_req_valid_o, "R3 request raised", ic_req_valid_o, 1);
    for (int i = 0; i < ic_ref; i++) begin
      nxt(); #1;
      chk(state_o == 3'd2 && !ic_req_valid_o, "R3 parked", state_o, 2);
      nxt(); ic_retry_i = 1; ic_req_ready_i = (i == ic_ref - 1); #1;
      chk(ic_req_valid_o, "R3 resend on retry", ic_req_valid_o, 1);
    end
    nxt(); #1; chk(state_o == 3'd3, "R3 wait", state_o, 3);
    if (drain_mid) chk(!drained_o, "R10 deferred", drained_o, 0);
    nxt(); ic_rsp_valid_i = 1; #1; chk(ic_rsp_ready_o, "R4 ready", ic_rsp_ready_o, 1);
    nxt(); exec_is_mem_i = ismem; if (!ismem) exp_q.push_back(1); #1;
    chk(!ic_rsp_ready_o, "R4 held", ic_rsp_ready_o, 0);
    chk(dxlate_req_o == ismem, "R6 data translation", dxlate_req_o, ismem);
    if (!ismem) begin
      nxt(); #1; chk(state_o == 3'd1, "R5 running", state_o, 1);
      return;
    end
    nxt(); #1; chk(state_o == 3'd4, "R6 translation wait", state_o, 4);
    nxt(); dxlate_done_i = 1; dxlate_fault_i = dfault; dc_req_ready_i = (dc_ref == 0);
    if (dfault) exp_q.push_back(2);
    #1;
    if (dfault) begin
      chk(!dc_req_valid_o, "R8 no data request", dc_req_valid_o, 0);
      fault_tail();
      return;
    end
    chk(dc_req_valid_o, "R7 data request", dc_req_valid_o, 1);
    for (int i = 0; i < dc_ref; i++) begin
      nxt(); #1;
      chk(state_o == 3'd5 && !dc_req_valid_o, "R7 parked", state_o, 5);
      nxt(); dc_retry_i = 1; dc_req_ready_i = (i == dc_ref - 1); #1;
      chk(dc_req_valid_o, "R7 resend on retry", dc_req_valid_o, 1);
    end
    nxt(); #1; chk(state_o == 3'd6, "R7 wait", state_o, 6);
    for (int i = 0; i < dc_lat; i++) begin
      nxt(); #1; chk(state_o == 3'd6 && !pc_advance_o, "R7 still waiting", state_o, 6);
    end
    nxt(); dc_rsp_valid_i = 1; #1; chk(dc_rsp_ready_o, "R4 data ready", dc_rsp_ready_o, 1);
    nxt(); dc_rsp_valid_i = 1; exp_q.push_back(1); #1;
    chk(!dc_rsp_ready_o, "R4 second refused", dc_rsp_ready_o, 0);
    nxt(); #1;
    chk(state_o == 3'd1, "R7 running", state_o, 1);
    chk(dc_rsp_ready_o, "R4 second not captured", dc_rsp_ready_o, 1);
  endtask

  task automatic activate(int d);
    int k;
    nxt(); activate_i = 1; act_delay_i = d[DLY_W-1:0];
    k = 0;
    for (int n = 1; n < 40; n++) begin
      nxt(); #1;
      if (fetch_strobe_o) begin k = n; break; end
    end
    chk(k == d + 2, "R2 activation delay", k, d + 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(state_o == 3'd0 && !fetch_strobe_o && !drained_o, "R1 reset state", state_o, 0);
    chk(cycles_o == 0 && ic_rsp_ready_o && dc_rsp_ready_o, "R1 reset count", cycles_o, 0);
    @(negedge clk); rst_n = 1;
    #1; chk(state_o == 3'd0 && !fetch_strobe_o, "R1 after release", state_o, 0);

    // drain while idle
    nxt(); drain_req_i = 1;
    nxt(); #1; chk(drained_o, "R10 idle drain", drained_o, 1);
    nxt(); drain_req_i = 0;
    nxt(); #1; chk(!drained_o, "R10 release", drained_o, 0);

    activate(3);
    nxt(); activate_i = 1; act_delay_i = 0; #1;
    chk(state_o == 3'd1, "R2 activate ignored when running", state_o, 1);
    // the strobe cycle was consumed above, so restart from a boundary
    run_instr(0, 0, 0, 0, 0, 0, 0, 0);
    #1; chk(fetch_strobe_o, "R5 next fetch", fetch_strobe_o, 1);
    run_instr(0, 2, 0, 0, 0, 0, 0, 0);
    run_instr(0, 0, 1, 0, 0, 0, 0, 0);
    run_instr(0, 1, 1, 0, 2, 3, 0, 0);
    run_instr(1, 0, 0, 0, 0, 0, 0, 0);
    chk(fetch_strobe_o, "R8 fetch after fault", fetch_strobe_o, 1);
    run_instr(0, 0, 1, 1, 0, 0, 0, 0);
    chk(fetch_strobe_o, "R8 fetch after data fault", fetch_strobe_o, 1);

    // drain during an instruction
    run_instr(0, 0, 1, 0, 0, 1, 1, 0);
    chk(!fetch_strobe_o && !drained_o, "R10 boundary reached", drained_o, 0);
    nxt(); #1; chk(drained_o && !fetch_strobe_o, "R10 drained after completion", drained_o, 1);
    nxt(); drain_req_i = 0; #1; chk(fetch_strobe_o, "R10 fetch resumes", fetch_strobe_o, 1);

    // suspend during an instruction
    run_instr(0, 0, 0, 0, 0, 0, 0, 1);
    chk(!fetch_strobe_o, "R9 no fetch after suspend", fetch_strobe_o, 0);
    nxt(); #1; chk(state_o == 3'd0, "R9 idle", state_o, 0);
    for (int i = 0; i < 3; i++) begin
      nxt(); #1; chk(!fetch_strobe_o && state_o == 3'd0, "R9 stays idle", state_o, 0);
    end
    activate(0);
    run_instr(0, 0, 0, 0, 0, 0, 0, 0);

    nxt(); nxt(); #3;
    chk(exp_q.size() == 0, "R5 scoreboard drained", exp_q.size(), 0);
    finish_up();
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_up();
  end
endmodule